// File: doc/BRIEF.md
# Routing Path Stuck-at Tester

This block supports testing of the programmable routing in a configurable fabric. A single pattern source drives a known logic level into every configured route: a low phase first, then a high phase. At the far end of the routes sits a row of analyzer cells. Each cell owns several incoming route ends and picks one of them with a multiplexer. The select for this multiplexer is one input shared by every cell. On a capture strobe, each cell loads the chosen route end into its capture flop and compares it with the level being driven. A disagreement sets a sticky fail flag for that cell.

The capture flops also form a scan chain. After a capture the results can be shifted out serially, last cell first. Cell c owns route ends c*NUM_SEL to c*NUM_SEL+NUM_SEL-1 of the route-end bus. Select value s picks end c*NUM_SEL+s in every cell at the same time. Routes that do not cross are therefore all tested in parallel. A failure is traced to one cell and one select value by running one select value per clear.

Top module: `route_probe`

## Requirements
- R1: After reset, pat_o is 0, every fail_o bit is 0 and scan_out_o is 0.
- R2: pat_o is 0 after reset or clear_i. It becomes 1 one cycle after phase_step_i is high, and stays 1 until the next clear_i.
- R3: When capture_i is high, scan_en_i is low and sel_i is below NUM_SEL, every cell c loads route_end_i[c*NUM_SEL+sel_i] into its capture flop at the clock edge.
- R4: A capture under R3 whose captured value differs from pat_o sets fail_o[c] one cycle later. The bit then stays set until clear_i or reset.
- R5: clear_i zeroes all of fail_o at the next edge and takes priority over a capture in the same cycle.
- R6: scan_out_o always shows the capture flop of cell NUM_CELLS-1. Each cycle with scan_en_i high moves cell c-1's flop into cell c, and scan_in_i into cell 0.
- R7: A capture strobe in a cycle with scan_en_i high is ignored: fail_o does not change.
- R8: A capture with sel_i of NUM_SEL or more is ignored. The capture flops hold their values and fail_o does not change.
- R9: A stuck-at fault on one route end sets fail_o only for the cell that owns it, and only during the runs that select it. Both phases are needed to catch both fault polarities.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Restart a test: low phase, fail flags cleared |
| phase_step_i | input | 1 | Move the pattern source to the high phase |
| capture_i | input | 1 | One-cycle capture strobe for all cells |
| sel_i | input | SEL_W | Route select shared by all cells |
| scan_en_i | input | 1 | Shift the capture chain one place |
| scan_in_i | input | 1 | Serial input into cell 0 |
| route_end_i | input | NUM_CELLS*NUM_SEL | Far ends of the routes under test |
| pat_o | output | 1 | Level driven into the routes |
| fail_o | output | NUM_CELLS | Sticky mismatch flag for each cell |
| scan_out_o | output | 1 | Serial output, last cell first |

## Verification
The hardest state to reach is a set of faults that sits inside one cell and one select value. Each fault must show in only one of the two phases, while the other routes of the same cell stay clean. The bench models the fabric as wires that carry pat_o unless forced stuck. It injects random stuck-at-0 and stuck-at-1 faults on random route ends. It then runs a low-phase and a high-phase capture for each select value separately, so each fail bit and each scanned bit maps to exactly one route. Collisions on the capture strobe (with clear, with scan enable, and with a select value outside the valid range) are forced on purpose with a planted fault that would otherwise set a flag.

// File: rtl/rtpa_pkg.sv
package rtpa_pkg;

   typedef enum logic {
      PH_LOW  = 1'b0,
      PH_HIGH = 1'b1
   } phase_e;

   function automatic int sel_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/rtpa_gen.sv
module rtpa_gen
   import rtpa_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic step_i,
   output logic pat_o
);

   phase_e ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ph_q <= PH_LOW;
      else if (clear_i) ph_q <= PH_LOW;
      else if (step_i)  ph_q <= PH_HIGH;
   end

   assign pat_o = (ph_q == PH_HIGH);

   p_phase_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pat_o && !clear_i) |=> pat_o);

   p_phase_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> !pat_o);

endmodule

// File: rtl/rtpa_route_mux.sv
module rtpa_route_mux #(
   parameter int NUM_SEL = 3,
   parameter int SEL_W   = rtpa_pkg::sel_width(NUM_SEL)
) (
   input  logic [NUM_SEL-1:0] ends_i,
   input  logic [SEL_W-1:0]   sel_i,
   output logic               pick_o,
   output logic               valid_o
);

   generate
      if (NUM_SEL == 1) begin : g_single
         assign valid_o = (sel_i == '0);
         assign pick_o  = ends_i[0];
      end else if ((1 << SEL_W) == NUM_SEL) begin : g_full
         assign valid_o = 1'b1;
         assign pick_o  = ends_i[sel_i];
      end else begin : g_partial
         always_comb begin
            valid_o = 1'b0;
            pick_o  = 1'b0;
            for (int i = 0; i < NUM_SEL; i++) begin
               if (sel_i == SEL_W'(i)) begin
                  valid_o = 1'b1;
                  pick_o  = ends_i[i];
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/rtpa_cell.sv
module rtpa_cell #(
   parameter int NUM_SEL = 3,
   parameter int SEL_W   = rtpa_pkg::sel_width(NUM_SEL)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear_i,
   input  logic               capture_i,
   input  logic               scan_en_i,
   input  logic [SEL_W-1:0]   sel_i,
   input  logic [NUM_SEL-1:0] ends_i,
   input  logic               expect_i,
   input  logic               scan_in_i,
   output logic               cap_q_o,
   output logic               fail_o
);

   logic pick, valid, take;

   rtpa_route_mux #(.NUM_SEL(NUM_SEL), .SEL_W(SEL_W)) u_mux (
      .ends_i (ends_i),
      .sel_i  (sel_i),
      .pick_o (pick),
      .valid_o(valid)
   );

   assign take = capture_i && valid && !scan_en_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cap_q_o <= 1'b0;
      else if (scan_en_i) cap_q_o <= scan_in_i;
      else if (take)      cap_q_o <= pick;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           fail_o <= 1'b0;
      else if (clear_i)                     fail_o <= 1'b0;
      else if (take && (pick != expect_i))  fail_o <= 1'b1;
   end

   p_fail_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fail_o && !clear_i) |=> fail_o);

   p_mismatch_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (capture_i && valid && !scan_en_i && !clear_i)
         |=> ((cap_q_o != $past(expect_i)) -> fail_o));

   p_clear_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> !fail_o);

   p_shift_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      scan_en_i |=> (cap_q_o == $past(scan_in_i)));

   p_scan_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_en_i && !clear_i) |=> $stable(fail_o));

   p_bad_sel_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (capture_i && !valid && !scan_en_i) |=> $stable(cap_q_o));

endmodule

// File: rtl/route_probe.sv
module route_probe #(
   parameter int NUM_CELLS = 4,
   parameter int NUM_SEL   = 3,
   parameter int SEL_W     = rtpa_pkg::sel_width(NUM_SEL),
   parameter int NUM_ROUTES = NUM_CELLS * NUM_SEL
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clear_i,
   input  logic                  phase_step_i,
   input  logic                  capture_i,
   input  logic [SEL_W-1:0]      sel_i,
   input  logic                  scan_en_i,
   input  logic                  scan_in_i,
   input  logic [NUM_ROUTES-1:0] route_end_i,
   output logic                  pat_o,
   output logic [NUM_CELLS-1:0]  fail_o,
   output logic                  scan_out_o
);

   generate
      if (NUM_CELLS < 1) begin : g_bad_cells
         $error("route_probe: NUM_CELLS must be at least 1");
      end
      if (NUM_SEL < 1) begin : g_bad_sel
         $error("route_probe: NUM_SEL must be at least 1");
      end
      if ((1 << SEL_W) < NUM_SEL) begin : g_bad_selw
         $error("route_probe: SEL_W too narrow for NUM_SEL");
      end
      if (NUM_ROUTES != NUM_CELLS * NUM_SEL) begin : g_bad_routes
         $error("route_probe: NUM_ROUTES must equal NUM_CELLS*NUM_SEL");
      end
   endgenerate

   logic [NUM_CELLS-1:0] cap_q;
   logic [NUM_CELLS-1:0] chain_in;

   rtpa_gen u_gen (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear_i(clear_i),
      .step_i (phase_step_i),
      .pat_o  (pat_o)
   );

   generate
      for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
         if (c == 0) begin : g_head
            assign chain_in[c] = scan_in_i;
         end else begin : g_link
            assign chain_in[c] = cap_q[c-1];
         end

         rtpa_cell #(.NUM_SEL(NUM_SEL), .SEL_W(SEL_W)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear_i  (clear_i),
            .capture_i(capture_i),
            .scan_en_i(scan_en_i),
            .sel_i    (sel_i),
            .ends_i   (route_end_i[c*NUM_SEL +: NUM_SEL]),
            .expect_i (pat_o),
            .scan_in_i(chain_in[c]),
            .cap_q_o  (cap_q[c]),
            .fail_o   (fail_o[c])
         );
      end
   endgenerate

   assign scan_out_o = cap_q[NUM_CELLS-1];

   generate
      if (NUM_CELLS > 1) begin : g_chain_chk
         p_scan_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
            scan_en_i |=> (scan_out_o == $past(cap_q[NUM_CELLS-2])));
      end
   endgenerate

   p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (fail_o == '0));

endmodule

// File: tb/route_probe_test.sv
`timescale 1ns/1ps
module route_probe_test;

   localparam int NC = 4;
   localparam int NS = 3;
   localparam int SW = 2;
   localparam int NR = NC * NS;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clear_i = 1'b0, phase_step_i = 1'b0, capture_i = 1'b0;
   logic scan_en_i = 1'b0, scan_in_i = 1'b0;
   logic [SW-1:0] sel_i = '0;
   logic [NR-1:0] route_end;
   logic pat_o, scan_out_o;
   logic [NC-1:0] fail_o;

   logic [NR-1:0] stk_en = '0, stk_val = '0;

   assign route_end = (stk_en & stk_val) | (~stk_en & {NR{pat_o}});

   always #2.5 clk = ~clk;

   route_probe #(.NUM_CELLS(NC), .NUM_SEL(NS)) uut (
      .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .phase_step_i(phase_step_i),
      .capture_i(capture_i), .sel_i(sel_i), .scan_en_i(scan_en_i),
      .scan_in_i(scan_in_i), .route_end_i(route_end), .pat_o(pat_o),
      .fail_o(fail_o), .scan_out_o(scan_out_o)
   );

   typedef struct {
      int          kind;   // 0 fail_o, 1 pat_o, 2 scan_out_o
      logic [31:0] exp;
      string       req;
   } item_t;

   item_t sb[$];
   event  chk_ev;
   int    checks = 0, errors = 0;
   bit    done = 0;

   // monitor: pops expected items and compares with the outputs
   initial begin
      forever begin
         @(chk_ev);
         while (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            case (it.kind)
               0: act = 32'(fail_o);
               1: act = 32'(pat_o);
               default: act = 32'(scan_out_o);
            endcase
            checks++;
            if (act !== it.exp) begin
               errors++;
               $display("FAIL %s kind %0d actual %0h expected %0h", it.req, it.kind, act, it.exp);
            end
         end
      end
   end

   task automatic expect_now(input int kind, input logic [31:0] exp, input string req);
      item_t it;
      it.kind = kind; it.exp = exp; it.req = req;
      sb.push_back(it);
      -> chk_ev;
      #0.1;
   endtask

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic do_clear();
      clear_i = 1'b1; cyc(); clear_i = 1'b0;
   endtask

   task automatic do_step();
      phase_step_i = 1'b1; cyc(); phase_step_i = 1'b0;
   endtask

   task automatic do_capture(input int s);
      sel_i = SW'(s); capture_i = 1'b1; cyc(); capture_i = 1'b0;
   endtask

   // reads the chain, last cell first; expv[c] is cell c's flop
   task automatic scan_read(input logic [NC-1:0] expv, input string req);
      for (int i = 0; i < NC; i++) begin
         expect_now(2, 32'(expv[NC-1-i]), req);
         if (i < NC - 1) begin
            scan_en_i = 1'b1; cyc(); scan_en_i = 1'b0;
         end
      end
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual hung expected finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [NC-1:0] ef, es;
      void'($urandom(17));
      cyc(); cyc();
      rst_n = 1'b1;
      cyc();
      // R1 reset state
      expect_now(1, 0, "R1 pat after reset");
      expect_now(0, 0, "R1 fail after reset");
      expect_now(2, 0, "R1 scan_out after reset");

      // R2 phase sequence
      do_step();
      expect_now(1, 1, "R2 pat high after step");
      cyc();
      expect_now(1, 1, "R2 pat holds high");
      do_clear();
      expect_now(1, 0, "R2 pat low after clear");

      // R5 clear beats a capture in the same cycle
      stk_en = '0; stk_val = '0;
      stk_en[1*NS+0] = 1'b1; stk_val[1*NS+0] = 1'b1;
      sel_i = '0; clear_i = 1'b1; capture_i = 1'b1; cyc();
      clear_i = 1'b0; capture_i = 1'b0;
      expect_now(0, 0, "R5 clear wins over capture");
      do_capture(0);
      expect_now(0, 32'b0010, "R4 stuck1 in low phase flags cell1");
      cyc();
      expect_now(0, 32'b0010, "R4 flag is sticky");
      do_clear();
      expect_now(0, 0, "R5 clear zeroes flags");

      // R7 scan enable blocks capture
      stk_en = '0; stk_val = '0;
      stk_en[2*NS+1] = 1'b1; stk_val[2*NS+1] = 1'b1;
      sel_i = SW'(1); capture_i = 1'b1; scan_en_i = 1'b1; cyc();
      capture_i = 1'b0; scan_en_i = 1'b0;
      expect_now(0, 0, "R7 capture ignored during scan");

      // R8 out-of-range select
      do_clear();
      stk_en = '0; stk_val = '0;
      do_step();
      do_capture(0);
      expect_now(0, 0, "R3 clean high capture");
      stk_en = '1; stk_val = '0;
      do_capture(3);
      expect_now(0, 0, "R8 bad select leaves flags");
      scan_read('1, "R8 bad select keeps flops");

      // R3 R4 R6 R9 random stuck-at faults, one select per run
      for (int r = 0; r < 8; r++) begin
         stk_en  = NR'($urandom) & NR'($urandom);
         stk_val = NR'($urandom);
         for (int s = 0; s < NS; s++) begin
            do_clear();
            do_capture(s);
            do_step();
            do_capture(s);
            for (int c = 0; c < NC; c++) begin
               ef[c] = stk_en[c*NS+s];
               es[c] = stk_en[c*NS+s] ? stk_val[c*NS+s] : 1'b1;
            end
            expect_now(0, 32'(ef), "R9 fault localization by cell and select");
            scan_read(es, "R6 scan shows captured route ends R3");
         end
      end

      cyc();
      done = 1;
      #1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule